// File: doc/BRIEF.md
# Byte-Code ALU with Status Flags and Return Condition

This block is the arithmetic core of a small byte-code processor. The core presents two operand values and a 3-bit operation code. The ALU then returns the result and a write enable in the same cycle. On the next clock edge it updates the status register, which holds the zero, sign, carry and odd-parity flags. The operation codes are add, subtract, AND, OR, XOR and move. Move copies the right operand into the left.

The status register is the first accumulator of the register file, so the core may also name it as a destination. When that happens, the computed byte is stored there in place of the flag update. A separate condition port serves the conditional-return opcodes. The core selects one of the four flags and an optional inversion. The ALU answers combinationally whether the return is taken, judged on the flags currently held.

The datapath is a plain control-path block. The core cannot stall it and holds no credit against it, so there is no ready signal. An operation is accepted in every cycle in which `op_valid` is high.

Top module: `wyg_alu_core`

## Requirements
- R1: Code 0 (add) gives result = (left + right) mod 256, and the carry flag is the carry out of bit 7.
- R2: Code 1 (subtract) gives result = (left - right) mod 256, and the carry flag is set exactly when left < right unsigned (a borrow).
- R3: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands, and clear the carry flag.
- R4: Code 5 (move) gives result = right and leaves the status register unchanged. Codes 6 and 7 are reserved: res_we stays low and the status register is unchanged. For codes 0 to 5, res_we equals op_valid.
- R5: After a valid code 0 to 4 whose destination is not the status register, the flags take these values on the next edge: zero = (result == 0), sign = result bit 7, parity-odd = odd number of ones in the result.
- R6: Status register layout: bit 0 carry, bit 1 parity-odd, bit 6 zero, bit 7 sign. Bits 2 to 5 always read 0. Reset clears the whole register.
- R7: When a valid code 0 to 5 has dst_is_psw high, the status register loads the result masked to bits 0, 1, 6 and 7. This write takes priority over the flag update.
- R8: ret_take = ret_valid AND (flag XOR ret_neg). The flag is chosen by ret_sel: 0 zero, 1 sign, 2 carry, 3 parity-odd. With ret_neg = 1 the tests become not-zero, not-sign, no-carry and parity-even.
- R9: While op_valid is low, the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 move, 6-7 reserved |
| left_val | input | 8 | Left (destination) operand value |
| right_val | input | 8 | Right operand value |
| dst_is_psw | input | 1 | Destination register is the status register |
| ret_valid | input | 1 | A conditional-return opcode is being evaluated |
| ret_sel | input | 2 | Flag select: 0 zero, 1 sign, 2 carry, 3 parity-odd |
| ret_neg | input | 1 | Invert the selected flag test |
| result | output | 8 | Computed byte |
| res_we | output | 1 | Write the result to the destination register |
| ret_take | output | 1 | Take the conditional return |
| psw | output | 8 | Status register contents |

## Verification
The assertions assume that every input is a known value whenever reset is released. They also assume that the core drives dst_is_psw only as a qualifier of a valid operation, and that nothing but this block writes the status register. The stimulus changes all inputs only on the falling clock edge and draws every field from its full legal range, reserved operation codes included. Idle cycles and status-register destinations are mixed in at fixed rates. Directed cases add the carry and borrow limits (0xFF plus 1, 0 minus 1) and an all-ones result, which has even parity.

// File: rtl/wyg_alu_pkg.sv
package wyg_alu_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_MOV = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    CND_ZERO  = 2'd0,
    CND_SIGN  = 2'd1,
    CND_CARRY = 2'd2,
    CND_PODD  = 2'd3
  } cond_sel_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic cf;
    logic po;
  } flag_set_t;
endpackage

// File: rtl/wyg_alu_datapath.sv
module wyg_alu_datapath
  import wyg_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           carry,
  output logic           known_op,
  output logic           sets_flags
);
  logic [W:0] sum_ext;
  logic [W:0] dif_ext;

  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign dif_ext = {1'b0, a} - {1'b0, b};

  always_comb begin
    res        = '0;
    carry      = 1'b0;
    known_op   = 1'b1;
    sets_flags = 1'b1;
    case (op)
      OP_ADD: begin
        res   = sum_ext[W-1:0];
        carry = sum_ext[W];
      end
      OP_SUB: begin
        res   = dif_ext[W-1:0];
        carry = dif_ext[W];
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_MOV: begin
        res        = b;
        sets_flags = 1'b0;
      end
      default: begin
        known_op   = 1'b0;
        sets_flags = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/wyg_alu_flag_gen.sv
module wyg_alu_flag_gen
  import wyg_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  input  logic         carry,
  output flag_set_t    flags
);
  always_comb begin
    flags.zf = (res == '0);
    flags.sf = res[W-1];
    flags.po = ^res;
    flags.cf = carry;
  end
endmodule

// File: rtl/wyg_alu_cond.sv
module wyg_alu_cond
  import wyg_alu_pkg::*;
(
  input  flag_set_t  held,
  input  logic       valid,
  input  logic [1:0] sel,
  input  logic       neg,
  output logic       take
);
  logic picked;

  always_comb begin
    case (cond_sel_e'(sel))
      CND_ZERO:  picked = held.zf;
      CND_SIGN:  picked = held.sf;
      CND_CARRY: picked = held.cf;
      default:   picked = held.po;
    endcase
    take = valid & (picked ^ neg);
  end
endmodule

// File: rtl/wyg_alu_core.sv
module wyg_alu_core
  import wyg_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   left_val,
  input  logic [W-1:0]   right_val,
  input  logic           dst_is_psw,
  input  logic           ret_valid,
  input  logic [1:0]     ret_sel,
  input  logic           ret_neg,
  output logic [W-1:0]   result,
  output logic           res_we,
  output logic           ret_take,
  output logic [W-1:0]   psw
);
  localparam int CF_POS = 0;
  localparam int PO_POS = 1;
  localparam int ZF_POS = W - 2;
  localparam int SF_POS = W - 1;
  localparam logic [W-1:0] KEEP_MASK =
    W'((1 << CF_POS) | (1 << PO_POS) | (1 << ZF_POS) | (1 << SF_POS));

  logic      carry_c;
  logic      known_c;
  logic      sets_c;
  flag_set_t new_f;
  flag_set_t held_f;
  logic [W-1:0] packed_f;
  logic [W-1:0] psw_q;

  wyg_alu_datapath #(.W(W)) u_dp (
    .op         (op_code),
    .a          (left_val),
    .b          (right_val),
    .res        (result),
    .carry      (carry_c),
    .known_op   (known_c),
    .sets_flags (sets_c)
  );

  wyg_alu_flag_gen #(.W(W)) u_fg (
    .res   (result),
    .carry (carry_c),
    .flags (new_f)
  );

  always_comb begin
    packed_f         = '0;
    packed_f[CF_POS] = new_f.cf;
    packed_f[PO_POS] = new_f.po;
    packed_f[ZF_POS] = new_f.zf;
    packed_f[SF_POS] = new_f.sf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw_q <= '0;
    end else if (op_valid && known_c) begin
      if (dst_is_psw) psw_q <= result & KEEP_MASK;
      else if (sets_c) psw_q <= packed_f;
    end
  end

  always_comb begin
    held_f.zf = psw_q[ZF_POS];
    held_f.sf = psw_q[SF_POS];
    held_f.cf = psw_q[CF_POS];
    held_f.po = psw_q[PO_POS];
  end

  wyg_alu_cond u_cond (
    .held  (held_f),
    .valid (ret_valid),
    .sel   (ret_sel),
    .neg   (ret_neg),
    .take  (ret_take)
  );

  assign res_we = op_valid & known_c;
  assign psw    = psw_q;
endmodule

// File: rtl/wyg_alu_core_chk.sv
module wyg_alu_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic [W-1:0] left_val,
  input logic [W-1:0] right_val,
  input logic         dst_is_psw,
  input logic         ret_valid,
  input logic [W-1:0] result,
  input logic         res_we,
  input logic         ret_take,
  input logic [W-1:0] psw
);
  localparam logic [W-1:0] KEEP = W'((1 << 0) | (1 << 1) | (1 << (W-2)) | (1 << (W-1)));

  // R6
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psw & ~KEEP) == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(psw));

  // R4
  move_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd5 && !dst_is_psw) |=> $stable(psw));

  // R4
  reserved_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd6 || op_code == 3'd7) |-> !res_we);

  // R7
  psw_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && dst_is_psw) |=> psw == ($past(result) & KEEP));

  // R3
  logic_clears_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dst_is_psw && (op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd4))
    |=> !psw[0]);

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dst_is_psw && op_code <= 3'd4) |=> psw[W-2] == ($past(result) == '0));

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0) |-> result == W'(left_val + right_val));

  // R8
  no_return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |-> !ret_take);
endmodule

bind wyg_alu_core wyg_alu_core_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .left_val   (left_val),
  .right_val  (right_val),
  .dst_is_psw (dst_is_psw),
  .ret_valid  (ret_valid),
  .result     (result),
  .res_we     (res_we),
  .ret_take   (ret_take),
  .psw        (psw)
);

// File: tb/wyg_alu_core_test.sv
`timescale 1ns/1ps
module wyg_alu_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [7:0] left_val = 8'd0;
  logic [7:0] right_val = 8'd0;
  logic       dst_is_psw = 1'b0;
  logic       ret_valid = 1'b0;
  logic [1:0] ret_sel = 2'd0;
  logic       ret_neg = 1'b0;
  logic [7:0] result;
  logic       res_we;
  logic       ret_take;
  logic [7:0] psw;

  int total = 0;
  int bad = 0;
  logic [7:0] m_psw = 8'h00;

  always #2.5 clk = ~clk;

  wyg_alu_core uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .left_val(left_val), .right_val(right_val), .dst_is_psw(dst_is_psw),
    .ret_valid(ret_valid), .ret_sel(ret_sel), .ret_neg(ret_neg),
    .result(result), .res_we(res_we), .ret_take(ret_take), .psw(psw)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {carry, result}
  function automatic logic [8:0] model_op(input logic [2:0] op, input logic [7:0] l, input logic [7:0] r);
    case (op)
      3'd0: return {1'b0, l} + {1'b0, r};
      3'd1: return {(l < r), 8'(l - r)};
      3'd2: return {1'b0, l & r};
      3'd3: return {1'b0, l | r};
      3'd4: return {1'b0, l ^ r};
      3'd5: return {1'b0, r};
      default: return 9'h000;
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3, 3'd4: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic step(input logic v, input logic [2:0] op, input logic [7:0] l, input logic [7:0] r,
                      input logic dst, input logic rv, input logic [1:0] rs, input logic rn);
    logic [8:0] e;
    logic fbit;
    logic e_take;
    @(negedge clk);
    op_valid = v; op_code = op; left_val = l; right_val = r;
    dst_is_psw = dst; ret_valid = rv; ret_sel = rs; ret_neg = rn;
    #1;
    e = model_op(op, l, r);
    if (op <= 3'd5) chk({op_tag(op), " result"}, {24'd0, result}, {24'd0, e[7:0]});
    chk("R4 res_we", {31'd0, res_we}, {31'd0, v && (op <= 3'd5)});
    case (rs)
      2'd0: fbit = m_psw[6];
      2'd1: fbit = m_psw[7];
      2'd2: fbit = m_psw[0];
      default: fbit = m_psw[1];
    endcase
    e_take = rv & (fbit ^ rn);
    chk("R8 ret_take", {31'd0, ret_take}, {31'd0, e_take});
    @(posedge clk);
    if (v && op <= 3'd5) begin
      if (dst) m_psw = e[7:0] & 8'hC3;
      else if (op != 3'd5)
        m_psw = {e[7], (e[7:0] == 8'd0), 4'b0000, ^e[7:0], e[8]};
    end
    #1;
    if (!v) chk("R9 psw idle", {24'd0, psw}, {24'd0, m_psw});
    else if (dst && op <= 3'd5) chk("R7 psw dest", {24'd0, psw}, {24'd0, m_psw});
    else if (op >= 3'd5) chk("R4 psw kept", {24'd0, psw}, {24'd0, m_psw});
    else chk({op_tag(op), "/R5 psw flags"}, {24'd0, psw}, {24'd0, m_psw});
    chk("R6 spare bits", {24'd0, psw & 8'h3C}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset psw", {24'd0, psw}, 32'd0);
    // directed corners
    step(1, 3'd0, 8'hFF, 8'h01, 0, 1, 2'd0, 0);   // R1 carry out, zero result
    step(1, 3'd0, 8'h00, 8'h00, 0, 1, 2'd0, 0);   // R8 zero set
    step(1, 3'd1, 8'h00, 8'h01, 0, 1, 2'd2, 0);   // R2 borrow, all ones
    step(1, 3'd1, 8'h05, 8'h05, 0, 1, 2'd3, 1);   // R2 no borrow, R8 parity-even
    step(1, 3'd2, 8'hF0, 8'h3C, 0, 1, 2'd2, 1);   // R3 carry cleared
    step(1, 3'd5, 8'h11, 8'h80, 0, 1, 2'd1, 0);   // R4 move keeps flags
    step(1, 3'd5, 8'h00, 8'hFF, 1, 1, 2'd1, 1);   // R7 move into status
    step(1, 3'd6, 8'h12, 8'h34, 0, 1, 2'd1, 0);   // R4 reserved
    step(1, 3'd0, 8'h02, 8'h01, 1, 0, 2'd0, 0);   // R7 priority over flags
    step(0, 3'd0, 8'hFF, 8'hFF, 0, 1, 2'd3, 0);   // R9 idle
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, 3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom),
           ($urandom % 6) == 0, 1'($urandom), 2'($urandom), 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule